// File: doc/BRIEF.md
# Receive Ping-Pong Buffer DMA Controller

This block moves received bytes from the receive FIFO into host memory. The host sets up two buffer descriptors, A and B. Each descriptor holds a base address and a buffer size in bytes, and writing a descriptor marks that buffer ready. The controller packs incoming bytes into 16-bit words, high byte first, and writes each word to memory through a request/grant bus. When a frame ends, it closes the buffer in use: it records the byte count, sets the buffer's completion bit, clears its ready flag and pulses a completion interrupt.

When a frame outgrows its buffer, the controller does not abort the frame. It pulses that buffer's overrun interrupt and carries on writing the same frame at the base of the other buffer, provided that buffer is ready. Reception stops only when there is nowhere left to write, which is the fatal case. In that case the controller pulses the FIFO-overrun interrupt and drops the receive enable. From then on, incoming bytes are drained and discarded until the host enables reception again.

The byte input is a valid/ready stream, and `in_last` marks the final byte of a frame (CRC bytes included). The controller applies back-pressure only while a word write is waiting for its grant, so `in_ready` is low exactly while `bus_req` is high. A byte is taken on any clock edge where `in_valid` and `in_ready` are both high. While the receiver is disabled, `in_ready` stays high and accepted bytes are thrown away.

Top module: `rx_pingpong_dma`

## Requirements
- R1: After reset, `rx_en`, `buf_ready`, `buf_done`, `bus_req`, all interrupt outputs and both frame lengths are 0, and `in_ready` is 1.
- R2: Writing a descriptor (`desc_sel` 0 selects A, 1 selects B) stores its base and size, sets its `buf_ready` bit and clears its `buf_done` bit. A pulse on `rx_en_set` turns reception on only if at least one `buf_ready` bit is set; otherwise the pulse is ignored.
- R3: Byte k of the data placed in a buffer is written at byte address base+k. Bytes are packed in pairs: the even byte goes to `bus_data[15:8]` and the odd byte to `bus_data[7:0]`, with `bus_be` = 2'b11. A word holding only one byte (the end of a frame or the end of a buffer) has `bus_be` = 2'b10, so only the high byte is written.
- R4: No byte is ever written outside [base, base+size) of the buffer in use.
- R5: If both buffers are ready when a frame starts, the frame goes to A. Once a buffer closes, the next frame goes to the buffer that is still ready.
- R6: When a frame ends, after the grant of its last word the buffer shows `buf_done`=1 and `buf_ready`=0, its frame length equals the number of frame bytes it holds, and its `irq_done` bit pulses for one cycle. A size field of 0 means 4096 bytes, and a count of 4096 reads back as 0.
- R7: If a frame still has bytes left after filling its buffer, that buffer's `irq_bovf` bit pulses. The buffer ends with `buf_ready`=0, `buf_done`=0 and a frame length equal to its size, and the frame continues from the base of the other buffer if that buffer is ready.
- R8: If a byte arrives with no buffer ready, or a buffer overflows while the other one is not ready, `irq_fovr` pulses and `rx_en` drops. After that, bytes are accepted and discarded and no bus request is made.
- R9: While `bus_req` is high and `bus_gnt` is low, `bus_req`, `bus_addr`, `bus_data` and `bus_be` hold their values and `in_ready` is 0. A grant completes exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_set | input | 1 | Pulse that turns reception on |
| rx_en | output | 1 | Receive enable |
| desc_wr | input | 1 | Descriptor write strobe |
| desc_sel | input | 1 | Descriptor select: 0 for A, 1 for B |
| desc_base | input | 16 | Buffer base byte address (even) |
| desc_len | input | 12 | Buffer size in bytes, 0 meaning 4096 |
| in_valid | input | 1 | A received byte is offered |
| in_ready | output | 1 | The controller takes the byte |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | The byte is the last one of its frame |
| bus_req | output | 1 | A word write is pending |
| bus_gnt | input | 1 | The pending write is granted this cycle |
| bus_addr | output | 16 | Byte address of the word |
| bus_data | output | 16 | Word data, high byte first |
| bus_be | output | 2 | Byte enables: bit 1 for high, bit 0 for low |
| buf_ready | output | 2 | Ready flags (bit 0 for A, bit 1 for B) |
| buf_done | output | 2 | Completion status bits |
| flen_a | output | 12 | Byte count latched for A |
| flen_b | output | 12 | Byte count latched for B |
| irq_done | output | 2 | Completion interrupt pulses |
| irq_bovf | output | 2 | Buffer overrun interrupt pulses |
| irq_fovr | output | 1 | FIFO overrun interrupt pulse |

## Verification
A wrong buffer choice or a stale ready flag shows up in the very next bus request: its address lands in the wrong region, or a frame that should have been written is silently discarded. A wrong byte counter or packing register shows up, at the latest, on the word that closes the frame or the buffer. It appears as a shifted address, a wrong byte enable, a byte written just past the region, or a wrong frame length one cycle after the final grant. The bench therefore sweeps every small pair of buffer sizes, frame lengths and ready states. It compares memory bytes inside and just around both regions, together with the status and interrupt counts.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  // Action carried by a pending word write, applied on its grant.
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_CLOSE  = 2'd1,
    ACT_SWITCH = 2'd2
  } act_e;
endpackage

// File: rtl/rxdma_desc.sv
module rxdma_desc #(
  parameter int AW = 16,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] base_in,
  input  logic [LW-1:0] len_in,
  input  logic          close,
  input  logic          drop,
  input  logic [LW-1:0] cnt_in,
  output logic [AW-1:0] base,
  output logic [LW:0]   size,
  output logic          ready,
  output logic          done,
  output logic [LW-1:0] flen
);
  logic [LW-1:0] len_q;

  // A stored size of 0 stands for the full 2**LW bytes.
  assign size = (len_q == '0) ? (LW+1)'(1 << LW) : {1'b0, len_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      len_q <= '0;
      ready <= 1'b0;
      done  <= 1'b0;
      flen  <= '0;
    end else if (close || drop) begin
      ready <= 1'b0;
      done  <= close;
      flen  <= cnt_in;
    end else if (wr) begin
      base  <= base_in;
      len_q <= len_in;
      ready <= 1'b1;
      done  <= 1'b0;
    end
  end

  a_r6_close_marks_done: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> done && !ready);
  a_r7_overrun_releases: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !close |=> !done && !ready);
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 12,
  parameter int BW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en_set,
  output logic                 rx_en,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BW-1:0]        in_data,
  input  logic                 in_last,
  output logic                 bus_req,
  input  logic                 bus_gnt,
  output logic [AW-1:0]        bus_addr,
  output logic [2*BW-1:0]      bus_data,
  output logic [1:0]           bus_be,
  input  logic [1:0][AW-1:0]   d_base,
  input  logic [1:0][LW:0]     d_size,
  input  logic [1:0]           d_ready,
  output logic [1:0]           d_close,
  output logic [1:0]           d_drop,
  output logic [LW-1:0]        d_count,
  output logic [1:0]           irq_done,
  output logic [1:0]           irq_bovf,
  output logic                 irq_fovr
);
  logic          active;
  logic          cur;
  logic [LW:0]   cnt;
  logic [BW-1:0] hold;
  act_e          act_q;

  logic          tgt, tgt_ok, odd, full, emit, take, fin;
  logic [LW:0]   ofs, nxt;
  logic [AW-1:0] waddr;

  // Buffer choice and position of the byte offered now.
  always_comb begin
    tgt    = active ? cur : ~d_ready[0];
    tgt_ok = active | d_ready[0] | d_ready[1];
    ofs    = active ? cnt : '0;
    nxt    = ofs + 1'b1;
    odd    = ofs[0];
    full   = (nxt == d_size[tgt]);
    emit   = odd | in_last | full;
    waddr  = {d_base[tgt][AW-1:1], 1'b0} + AW'({ofs[LW:1], 1'b0});
  end

  assign in_ready = ~bus_req;
  assign take     = in_valid & in_ready & rx_en;
  assign fin      = bus_req & bus_gnt;
  assign d_count  = cnt[LW-1:0];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      d_close[i] = fin && (act_q == ACT_CLOSE)  && (cur == 1'(i));
      d_drop[i]  = fin && (act_q == ACT_SWITCH) && (cur == 1'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      active   <= 1'b0;
      cur      <= 1'b0;
      cnt      <= '0;
      hold     <= '0;
      bus_req  <= 1'b0;
      bus_addr <= '0;
      bus_data <= '0;
      bus_be   <= '0;
      act_q    <= ACT_NONE;
      irq_done <= '0;
      irq_bovf <= '0;
      irq_fovr <= 1'b0;
    end else begin
      irq_done <= '0;
      irq_bovf <= '0;
      irq_fovr <= 1'b0;
      if (rx_en_set && (d_ready != 2'b00)) rx_en <= 1'b1;
      if (take) begin
        if (!tgt_ok) begin
          rx_en    <= 1'b0;
          irq_fovr <= 1'b1;
        end else begin
          active <= 1'b1;
          cur    <= tgt;
          cnt    <= nxt;
          if (!odd) hold <= in_data;
          if (emit) begin
            bus_req  <= 1'b1;
            bus_addr <= waddr;
            bus_data <= odd ? {hold, in_data} : {in_data, {BW{1'b0}}};
            bus_be   <= odd ? 2'b11 : 2'b10;
            act_q    <= in_last ? ACT_CLOSE : (full ? ACT_SWITCH : ACT_NONE);
          end
        end
      end
      if (fin) begin
        bus_req <= 1'b0;
        if (act_q == ACT_CLOSE) begin
          irq_done[cur] <= 1'b1;
          active        <= 1'b0;
          cnt           <= '0;
        end else if (act_q == ACT_SWITCH) begin
          irq_bovf[cur] <= 1'b1;
          cnt           <= '0;
          if (d_ready[~cur]) begin
            cur <= ~cur;
          end else begin
            active   <= 1'b0;
            rx_en    <= 1'b0;
            irq_fovr <= 1'b1;
          end
        end
      end
    end
  end

  a_r9_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_data) && $stable(bus_be));
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    take && tgt_ok |-> ofs < d_size[tgt]);
  a_r8_fovr_disables: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fovr |-> !rx_en);
  a_r2_enable_needs_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_en) |-> $past(d_ready != 2'b00));
  a_r5_a_first: assert property (@(posedge clk) disable iff (!rst_n)
    take && !active && d_ready[0] |=> cur == 1'b0);
endmodule

// File: rtl/rx_pingpong_dma.sv
module rx_pingpong_dma #(
  parameter int AW = 16,
  parameter int LW = 12,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en_set,
  output logic            rx_en,
  input  logic            desc_wr,
  input  logic            desc_sel,
  input  logic [AW-1:0]   desc_base,
  input  logic [LW-1:0]   desc_len,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [BW-1:0]   in_data,
  input  logic            in_last,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic [AW-1:0]   bus_addr,
  output logic [2*BW-1:0] bus_data,
  output logic [1:0]      bus_be,
  output logic [1:0]      buf_ready,
  output logic [1:0]      buf_done,
  output logic [LW-1:0]   flen_a,
  output logic [LW-1:0]   flen_b,
  output logic [1:0]      irq_done,
  output logic [1:0]      irq_bovf,
  output logic            irq_fovr
);
  localparam int NB = 2;

  logic [NB-1:0][AW-1:0] d_base;
  logic [NB-1:0][LW:0]   d_size;
  logic [NB-1:0]         d_close, d_drop;
  logic [NB-1:0][LW-1:0] d_flen;
  logic [LW-1:0]         d_count;

  for (genvar i = 0; i < NB; i++) begin : g_desc
    rxdma_desc #(.AW(AW), .LW(LW)) u_desc (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (desc_wr && (desc_sel == 1'(i))),
      .base_in (desc_base),
      .len_in  (desc_len),
      .close   (d_close[i]),
      .drop    (d_drop[i]),
      .cnt_in  (d_count),
      .base    (d_base[i]),
      .size    (d_size[i]),
      .ready   (buf_ready[i]),
      .done    (buf_done[i]),
      .flen    (d_flen[i])
    );
  end

  assign flen_a = d_flen[0];
  assign flen_b = d_flen[1];

  rxdma_engine #(.AW(AW), .LW(LW), .BW(BW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en_set (rx_en_set),
    .rx_en     (rx_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_be    (bus_be),
    .d_base    (d_base),
    .d_size    (d_size),
    .d_ready   (buf_ready),
    .d_close   (d_close),
    .d_drop    (d_drop),
    .d_count   (d_count),
    .irq_done  (irq_done),
    .irq_bovf  (irq_bovf),
    .irq_fovr  (irq_fovr)
  );
endmodule

// File: tb/rx_pingpong_dma_test.sv
`timescale 1ns/1ps
module rx_pingpong_dma_test;
  localparam int BA = 16'h0010;
  localparam int BB = 16'h0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en_set = 1'b0, rx_en;
  logic desc_wr = 1'b0, desc_sel = 1'b0;
  logic [15:0] desc_base = '0;
  logic [11:0] desc_len = '0;
  logic in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic bus_req, bus_gnt = 1'b0;
  logic [15:0] bus_addr, bus_data;
  logic [1:0] bus_be, buf_ready, buf_done, irq_done, irq_bovf;
  logic [11:0] flen_a, flen_b;
  logic irq_fovr;

  rx_pingpong_dma uut (.*);

  always #5 clk = ~clk;

  int nvec = 0, nerr = 0, cyc = 0, wcnt = 0;
  int gmode = 0;
  int ra_lo = 0, ra_hi = 0, rb_lo = 0, rb_hi = 0;
  int n_done0 = 0, n_done1 = 0, n_bo0 = 0, n_bo1 = 0, n_fovr = 0;
  bit finished = 0;
  logic [7:0] mem [0:511];
  bit p_pend = 0;
  logic [15:0] p_addr, p_data;
  logic [1:0] p_be;
  // scenario model
  int s_n, s_fb, s_fl, s_sb, s_sl;
  bit s_any, s_sok;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic bit in_region(input int a);
    return (a >= ra_lo && a < ra_hi) || (a >= rb_lo && a < rb_hi);
  endfunction

  // Grant driver and memory model; all sampling away from the rising edge.
  always @(negedge clk) begin
    bit g;
    cyc++;
    if (p_pend) begin
      chk("R9 req held", {31'd0, bus_req}, 1);
      chk("R9 addr held", {16'd0, bus_addr}, {16'd0, p_addr});
      chk("R9 data held", {16'd0, bus_data}, {16'd0, p_data});
      chk("R9 be held", {30'd0, bus_be}, {30'd0, p_be});
      chk("R9 ready low", {31'd0, in_ready}, 0);
    end
    g = (gmode == 0) ? 1'b1 : (cyc % 3 == 0);
    bus_gnt = g;
    if (bus_req === 1'b1 && g) begin
      for (int k = 0; k < 2; k++) begin
        if (bus_be[1-k]) begin
          int a;
          a = int'(bus_addr) + k;
          mem[a & 511] = bus_data[15-8*k -: 8];
          wcnt++;
          chk("R4 write in region", {31'd0, in_region(a)}, 1);
        end
      end
    end
    p_pend = (bus_req === 1'b1) && !g;
    p_addr = bus_addr; p_data = bus_data; p_be = bus_be;
    if (irq_done[0] === 1'b1) n_done0++;
    if (irq_done[1] === 1'b1) n_done1++;
    if (irq_bovf[0] === 1'b1) n_bo0++;
    if (irq_bovf[1] === 1'b1) n_bo1++;
    if (irq_fovr === 1'b1) n_fovr++;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wcnt = 0; n_done0 = 0; n_done1 = 0; n_bo0 = 0; n_bo1 = 0; n_fovr = 0;
    for (int i = 0; i < 512; i++) mem[i] = 8'hEE;
  endtask

  task automatic wdesc(input logic sel, input int base, input int len);
    desc_wr = 1'b1; desc_sel = sel; desc_base = 16'(base); desc_len = 12'(len);
    @(negedge clk);
    desc_wr = 1'b0;
  endtask

  task automatic enable();
    rx_en_set = 1'b1;
    @(negedge clk);
    rx_en_set = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic l);
    in_valid = 1'b1; in_data = b; in_last = l;
    while (in_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_idle();
    while (bus_req === 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic int pat(input int j);
    return (j * 37 + s_n * 11 + 3) & 255;
  endfunction

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int exp_at(input int a);
    if (!s_any) return 'hEE;
    if (a >= s_fb && a < s_fb + mn(s_n, s_fl)) return pat(a - s_fb);
    if (s_sok && s_n > s_fl && a >= s_sb && a < s_sb + mn(s_n - s_fl, s_sl))
      return pat(s_fl + a - s_sb);
    return 'hEE;
  endfunction

  task automatic run(input int la, input int lb, input bit ua, input bit ub, input int n, input int gm);
    logic [1:0] e_rdy, e_done;
    int e_fl0, e_fl1, e_bo0, e_bo1, e_fovr, e_wr, m, f;
    bit e_en;
    do_reset();
    gmode = gm;
    s_n = n; s_any = ua | ub; s_fb = ua ? BA : BB; s_fl = ua ? la : lb;
    s_sok = ua && ub; s_sb = BB; s_sl = lb;
    ra_lo = ua ? BA : 0; ra_hi = ua ? BA + la : 0;
    rb_lo = ub ? BB : 0; rb_hi = ub ? BB + lb : 0;
    if (ua) wdesc(1'b0, BA, la);
    if (ub) wdesc(1'b1, BB, lb);
    enable();
    for (int j = 0; j < n; j++) send(8'(pat(j)), j == n - 1);
    wait_idle();
    // arithmetic model of the expected outcome
    e_rdy = {ub, ua}; e_done = 2'b00; e_fl0 = 0; e_fl1 = 0; e_bo0 = 0; e_bo1 = 0;
    e_fovr = 0; e_en = s_any; e_wr = 0; f = ua ? 0 : 1;
    if (s_any) begin
      e_wr = mn(n, s_fl);
      if (n <= s_fl) begin
        e_done[f] = 1'b1; e_rdy[f] = 1'b0;
        if (f == 0) e_fl0 = n; else e_fl1 = n;
      end else begin
        e_rdy[f] = 1'b0;
        if (f == 0) begin e_bo0 = 1; e_fl0 = s_fl; end else begin e_bo1 = 1; e_fl1 = s_fl; end
        if (s_sok) begin
          m = n - s_fl; e_rdy[1] = 1'b0; e_wr += mn(m, s_sl);
          if (m <= s_sl) begin e_done[1] = 1'b1; e_fl1 = m; end
          else begin e_bo1 = 1; e_fl1 = s_sl; e_fovr = 1; e_en = 1'b0; end
        end else begin
          e_fovr = 1; e_en = 1'b0;
        end
      end
    end
    chk("R2 rx_en", {31'd0, rx_en}, {31'd0, e_en});
    chk("R6 buf_ready", {30'd0, buf_ready}, {30'd0, e_rdy});
    chk("R6 buf_done", {30'd0, buf_done}, {30'd0, e_done});
    chk("R6 flen_a", {20'd0, flen_a}, e_fl0);
    chk("R6 flen_b", {20'd0, flen_b}, e_fl1);
    chk("R6 irq_done A", n_done0, {31'd0, e_done[0]});
    chk("R6 irq_done B", n_done1, {31'd0, e_done[1]});
    chk("R7 irq_bovf A", n_bo0, e_bo0);
    chk("R7 irq_bovf B", n_bo1, e_bo1);
    chk("R8 irq_fovr", n_fovr, e_fovr);
    chk("R3 bytes written", wcnt, e_wr);
    for (int a = BA - 2; a < BA + 10; a++) chk("R3 mem A", {24'd0, mem[a & 511]}, exp_at(a));
    for (int a = BB - 2; a < BB + 10; a++) chk("R3 mem B", {24'd0, mem[a & 511]}, exp_at(a));
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'hEE;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 rx_en", {31'd0, rx_en}, 0);
    chk("R1 buf_ready", {30'd0, buf_ready}, 0);
    chk("R1 buf_done", {30'd0, buf_done}, 0);
    chk("R1 bus_req", {31'd0, bus_req}, 0);
    chk("R1 in_ready", {31'd0, in_ready}, 1);
    chk("R1 irqs", {27'd0, irq_done, irq_bovf, irq_fovr}, 0);
    chk("R1 flen", {8'd0, flen_a, flen_b}, 0);

    // R5 and R8: back-to-back frames, then data with no buffer left
    do_reset(); gmode = 1;
    ra_lo = BA; ra_hi = BA + 8; rb_lo = BB; rb_hi = BB + 8;
    wdesc(1'b0, BA, 8); wdesc(1'b1, BB, 8);
    chk("R2 ready after write", {30'd0, buf_ready}, 3);
    enable();
    for (int j = 0; j < 3; j++) send(8'(100 + j), j == 2);
    for (int j = 0; j < 4; j++) send(8'(200 + j), j == 3);
    wait_idle();
    for (int j = 0; j < 3; j++) chk("R5 frame 1 in A", {24'd0, mem[BA + j]}, 100 + j);
    for (int j = 0; j < 4; j++) chk("R5 frame 2 in B", {24'd0, mem[BB + j]}, 200 + j);
    chk("R5 A untouched after frame", {24'd0, mem[BA + 3]}, 'hEE);
    chk("R5 flen_a", {20'd0, flen_a}, 3);
    chk("R5 flen_b", {20'd0, flen_b}, 4);
    chk("R5 both done", {30'd0, buf_done}, 3);
    chk("R5 none ready", {30'd0, buf_ready}, 0);
    send(8'h55, 1'b0);
    repeat (2) @(negedge clk);
    chk("R8 fovr on empty", n_fovr, 1);
    chk("R8 rx_en dropped", {31'd0, rx_en}, 0);
    send(8'h56, 1'b0); send(8'h57, 1'b1);
    wait_idle();
    chk("R8 dropped bytes", wcnt, 7);
    chk("R8 in_ready while off", {31'd0, in_ready}, 1);
    enable();
    chk("R2 enable ignored without buffer", {31'd0, rx_en}, 0);

    // R6: size field 0 means 4096
    do_reset(); gmode = 0;
    ra_lo = BA; ra_hi = BA + 4096; rb_lo = 0; rb_hi = 0;
    wdesc(1'b0, BA, 0); enable();
    for (int j = 0; j < 5; j++) send(8'(j), j == 4);
    wait_idle();
    chk("R6 short frame in 4096 buffer", {20'd0, flen_a}, 5);
    chk("R6 done", {31'd0, buf_done[0]}, 1);
    wdesc(1'b0, BA, 0);
    wcnt = 0;
    for (int j = 0; j < 4096; j++) send(8'(j), j == 4095);
    wait_idle();
    chk("R6 full 4096 frame reads 0", {20'd0, flen_a}, 0);
    chk("R6 full frame done", {31'd0, buf_done[0]}, 1);
    chk("R7 no overrun at exact fit", n_bo0, 0);
    chk("R3 4096 bytes written", wcnt, 4096);

    // Sweep of small buffer sizes, frame lengths, ready states and grant patterns.
    for (int la = 1; la <= 5; la++)
      for (int lb = 1; lb <= 4; lb++)
        for (int u = 0; u < 4; u++) begin
          if (u == 0 && !(la == 1 && lb == 1)) continue;
          for (int n = 1; n <= la + lb + 1; n++)
            for (int gm = 0; gm < 2; gm++)
              run(la, lb, u[0], u[1], n, gm);
        end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule